// File: doc/BRIEF.md
# GPIO Interrupt Sense Unit

This block turns the 32 input pins of a GPIO port into interrupt requests. Each pin has a 4-bit sense code that chooses what the pin reacts to: a rising edge, a falling edge, either edge, a high level or a low level. A detected event sets the pin's bit in a raw pending vector. That bit stays set until software acknowledges it. The unit shares the port's 32-bit register bus: one write strobe, an 8-bit byte address and write data. Read data is combinational.

Two enable layers sit on the path to the interrupt lines. The first is a read-write accept mask, which decides whether a pin may record new events at all. The second is an interrupt enable, which software changes through separate set and clear addresses. The enable decides which pending bits show up in the masked status. Pins 0 to 15 drive one interrupt output and pins 16 to 31 drive the other. Pin inputs are assumed to be synchronised before they reach this block.

To change a pin's sense safely, software clears the pin's accept bit, rewrites the sense field, acknowledges the pin and then sets the accept bit again.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, the accept mask, the interrupt enables, the pending vector and all sense fields read 0, and both interrupt outputs are low.
- R2: Sense code 0x8 sets pin n pending on a 0-to-1 change of the pin and not on a 1-to-0 change.
- R3: Sense code 0x9 sets pin n pending on a 1-to-0 change of the pin and not on a 0-to-1 change.
- R4: Sense code 0xC sets pin n pending on a change in either direction.
- R5: Sense code 0xA sets pin n pending in every cycle the pin is 1, so an acknowledge while the pin stays high leaves the pin pending.
- R6: Sense code 0xB sets pin n pending in every cycle the pin is 0.
- R7: Any sense code other than 0x8, 0x9, 0xA, 0xB or 0xC detects nothing on either edge.
- R8: The accept mask at address 0x14 is read-write. While bit n is 0, pin n records no new event, and a bit that is already pending stays pending.
- R9: Writing bit n = 1 to address 0x18 enables pin n, and writing bit n = 1 to 0x1C disables it. Zero bits leave the enable unchanged. Both addresses read back the enable vector.
- R10: Address 0x20 reads the raw pending vector, and 0x24 reads the pending vector ANDed with the enable vector.
- R11: Writing bit n = 1 to address 0x28 clears pin n's pending bit, and zero bits have no effect. If an event on pin n falls in the same cycle as the acknowledge, the pin stays pending.
- R12: The low interrupt output is the OR of masked status bits 15..0, and the high output is the OR of bits 31..16.
- R13: Sense fields live at 0x40, 0x44, 0x48 and 0x4C, which are read-write. Pin n uses the register at 0x40 + 4*(n/8), bits [4*(n mod 8)+3 : 4*(n mod 8)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Synchronised pin levels |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| irq_lo_o | output | 1 | Interrupt request for pins 0..15 |
| irq_hi_o | output | 1 | Interrupt request for pins 16..31 |

## Verification
The hardest case to reach is an acknowledge write that lands in the same cycle as a fresh edge on the same pin. The bench first makes a rising-edge pin pending and lowers the pin. It then raises the pin and issues the acknowledge write on the same falling clock edge, so both are seen at one rising edge, and the pin must still read pending afterwards. A related case is the level-sensitive pin, which must survive an acknowledge while its level holds. The bench acknowledges it with the pin still high before releasing it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [3:0] {
    SNS_RISE = 4'h8,
    SNS_FALL = 4'h9,
    SNS_HIGH = 4'hA,
    SNS_LOW  = 4'hB,
    SNS_BOTH = 4'hC
  } sense_e;

  localparam logic [7:0] OFS_ACCEPT = 8'h14;
  localparam logic [7:0] OFS_EN_SET = 8'h18;
  localparam logic [7:0] OFS_EN_CLR = 8'h1C;
  localparam logic [7:0] OFS_RAW    = 8'h20;
  localparam logic [7:0] OFS_STATUS = 8'h24;
  localparam logic [7:0] OFS_ACK    = 8'h28;
  localparam logic [7:0] OFS_SENSE0 = 8'h40;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int SENSE_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [NPINS-1:0]         pend_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [NPINS-1:0]         accept_o,
  output logic [NPINS-1:0]         en_o,
  output logic [NPINS*SENSE_W-1:0] sense_o,
  output logic [NPINS-1:0]         ack_o
);
  localparam int FIELDS = DATA_W / SENSE_W;
  localparam int NREGS  = NPINS / FIELDS;

  logic [NPINS-1:0]             accept_q, en_q;
  logic [NREGS-1:0][DATA_W-1:0] sense_q;
  logic [NPINS-1:0]             en_set, en_clr;
  logic                         wr_accept, wr_set, wr_clr;

  assign wr_accept = we_i && (addr_i == ADDR_W'(OFS_ACCEPT));
  assign wr_set    = we_i && (addr_i == ADDR_W'(OFS_EN_SET));
  assign wr_clr    = we_i && (addr_i == ADDR_W'(OFS_EN_CLR));
  assign en_set    = wr_set ? wdata_i[NPINS-1:0] : '0;
  assign en_clr    = wr_clr ? wdata_i[NPINS-1:0] : '0;
  assign ack_o     = (we_i && (addr_i == ADDR_W'(OFS_ACK))) ? wdata_i[NPINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= '0;
      en_q     <= '0;
    end else begin
      if (wr_accept) accept_q <= wdata_i[NPINS-1:0];
      en_q <= (en_q | en_set) & ~en_clr;
    end
  end

  for (genvar m = 0; m < NREGS; m++) begin : g_sense
    logic wr_m;
    assign wr_m = we_i && (addr_i == ADDR_W'(OFS_SENSE0 + 4 * m));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   sense_q[m] <= '0;
      else if (wr_m) sense_q[m] <= wdata_i;
    end
  end

  assign accept_o = accept_q;
  assign en_o     = en_q;
  assign sense_o  = sense_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_ACCEPT)) rdata_o[NPINS-1:0] = accept_q;
    if (addr_i == ADDR_W'(OFS_EN_SET) || addr_i == ADDR_W'(OFS_EN_CLR)) rdata_o[NPINS-1:0] = en_q;
    if (addr_i == ADDR_W'(OFS_RAW))    rdata_o[NPINS-1:0] = pend_i;
    if (addr_i == ADDR_W'(OFS_STATUS)) rdata_o[NPINS-1:0] = pend_i & en_q;
    for (int m = 0; m < NREGS; m++)
      if (addr_i == ADDR_W'(OFS_SENSE0 + 4 * m)) rdata_o = sense_q[m];
  end

  // R9
  en_set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((en_q & $past(wdata_i[NPINS-1:0])) == $past(wdata_i[NPINS-1:0])));
  // R9
  en_clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((en_q & $past(wdata_i[NPINS-1:0])) == '0));
  // R9
  en_zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set || wr_clr) |=> ((en_q & ~$past(wdata_i[NPINS-1:0])) == ($past(en_q) & ~$past(wdata_i[NPINS-1:0]))));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int SENSE_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NPINS-1:0]         pin_i,
  input  logic [NPINS-1:0]         accept_i,
  input  logic [NPINS*SENSE_W-1:0] sense_i,
  output logic [NPINS-1:0]         evt_o
);
  logic [NPINS-1:0] prev_q;

  // tracks pins regardless of accept, so enabling later sees no stale edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [SENSE_W-1:0] code;
    logic               hit;
    assign code = sense_i[n*SENSE_W +: SENSE_W];
    always_comb begin
      case (code)
        SNS_RISE: hit =  pin_i[n] & ~prev_q[n];
        SNS_FALL: hit = ~pin_i[n] &  prev_q[n];
        SNS_HIGH: hit =  pin_i[n];
        SNS_LOW:  hit = ~pin_i[n];
        SNS_BOTH: hit =  pin_i[n] ^  prev_q[n];
        default:  hit = 1'b0;
      endcase
    end
    assign evt_o[n] = accept_i[n] & hit;
  end
endmodule

// File: rtl/gpio_irq_pend.sv
module gpio_irq_pend #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] evt_i,
  input  logic [NPINS-1:0] ack_i,
  input  logic [NPINS-1:0] en_i,
  output logic [NPINS-1:0] pend_o,
  output logic             irq_lo_o,
  output logic             irq_hi_o
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] pend_q, status;

  // a new event wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~ack_i) | evt_i;
  end

  assign status   = pend_q & en_i;
  assign pend_o   = pend_q;
  assign irq_lo_o = |status[HALF-1:0];
  assign irq_hi_o = |status[NPINS-1:HALF];

  // R11
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_i & ~evt_i)) |=> ((pend_q & $past(ack_i & ~evt_i)) == '0));
  // R11
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));
  // R8
  no_spurious_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int NPINS   = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int SENSE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  logic [NPINS-1:0]         accept, en, ack, evt, pend;
  logic [NPINS*SENSE_W-1:0] sense;

  gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SENSE_W(SENSE_W)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .pend_i(pend), .rdata_o(bus_rdata_o),
    .accept_o(accept), .en_o(en), .sense_o(sense), .ack_o(ack)
  );

  gpio_irq_detect #(.NPINS(NPINS), .SENSE_W(SENSE_W)) detect_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .accept_i(accept),
    .sense_i(sense), .evt_o(evt)
  );

  gpio_irq_pend #(.NPINS(NPINS)) pend_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .ack_i(ack), .en_i(en),
    .pend_o(pend), .irq_lo_o(irq_lo_o), .irq_hi_o(irq_hi_o)
  );

  // R12
  irq_lo_follows_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en[NPINS/2-1:0] == '0) |-> !irq_lo_o));
endmodule

// File: tb/gpio_irq_sense_tb.sv
module gpio_irq_sense_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;
  logic [31:0] sense_sh [4];
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_sense dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic set_pin(int n, logic v);
    @(negedge clk);
    pins[n] = v;
  endtask

  task automatic set_sense(int n, logic [3:0] code);
    sense_sh[n/8][(n%8)*4 +: 4] = code;
    wr(8'(8'h40 + 4*(n/8)), sense_sh[n/8]);
  endtask

  task automatic cleanup();
    for (int m = 0; m < 4; m++) begin
      sense_sh[m] = '0;
      wr(8'(8'h40 + 4*m), 32'h0);
    end
    @(negedge clk);
    pins = '0;
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h14, d); chk("R1 accept", d, 0);
    rd(8'h18, d); chk("R1 enable", d, 0);
    rd(8'h20, d); chk("R1 raw", d, 0);
    rd(8'h48, d); chk("R1 sense", d, 0);
    chk("R1 irqs", {30'd0, irq_hi, irq_lo}, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    set_sense(11, 4'h8);
    rd(8'h44, d); chk("R13 sense readback", d, 32'h0000_8000);
    set_pin(11, 1'b1);
    rd(8'h20, d); chk("R13 pin 11 field", d, 32'h1 << 11);
    cleanup();
  endtask

  task automatic t_rise();
    logic [31:0] d;
    set_sense(5, 4'h8);
    set_pin(5, 1'b1);
    rd(8'h20, d); chk("R2 rise", d, 32'h1 << 5);
    wr(8'h28, 32'h1 << 5);
    set_pin(5, 1'b0);
    rd(8'h20, d); chk("R2 fall ignored", d, 0);
    cleanup();
  endtask

  task automatic t_fall();
    logic [31:0] d;
    set_pin(20, 1'b1);
    set_sense(20, 4'h9);
    rd(8'h20, d); chk("R3 rise ignored", d, 0);
    set_pin(20, 1'b0);
    rd(8'h20, d); chk("R3 fall", d, 32'h1 << 20);
    cleanup();
  endtask

  task automatic t_both();
    logic [31:0] d;
    set_sense(30, 4'hC);
    set_pin(30, 1'b1);
    rd(8'h20, d); chk("R4 rise", d, 32'h1 << 30);
    wr(8'h28, 32'h1 << 30);
    rd(8'h20, d); chk("R4 ack", d, 0);
    set_pin(30, 1'b0);
    rd(8'h20, d); chk("R4 fall", d, 32'h1 << 30);
    cleanup();
  endtask

  task automatic t_level_high();
    logic [31:0] d;
    set_sense(2, 4'hA);
    rd(8'h20, d); chk("R5 low idle", d, 0);
    set_pin(2, 1'b1);
    rd(8'h20, d); chk("R5 high", d, 32'h1 << 2);
    wr(8'h28, 32'h1 << 2);
    rd(8'h20, d); chk("R5 ack while high", d, 32'h1 << 2);
    set_pin(2, 1'b0);
    wr(8'h28, 32'h1 << 2);
    rd(8'h20, d); chk("R5 ack after low", d, 0);
    cleanup();
  endtask

  task automatic t_level_low();
    logic [31:0] d;
    set_pin(17, 1'b1);
    set_sense(17, 4'hB);
    rd(8'h20, d); chk("R6 high idle", d, 0);
    set_pin(17, 1'b0);
    wr(8'h28, 32'h1 << 17);
    rd(8'h20, d); chk("R6 low", d, 32'h1 << 17);
    cleanup();
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    set_sense(9, 4'h7);
    set_sense(12, 4'hD);
    set_sense(13, 4'h0);
    set_pin(9, 1'b1); set_pin(12, 1'b1); set_pin(13, 1'b1);
    rd(8'h20, d); chk("R7 rise", d, 0);
    set_pin(9, 1'b0); set_pin(12, 1'b0); set_pin(13, 1'b0);
    rd(8'h20, d); chk("R7 fall", d, 0);
    cleanup();
  endtask

  task automatic t_accept();
    logic [31:0] d;
    set_sense(3, 4'h8);
    set_pin(3, 1'b1);
    wr(8'h14, ~(32'h1 << 3));
    rd(8'h14, d); chk("R8 accept readback", d, ~(32'h1 << 3));
    rd(8'h20, d); chk("R8 pending kept", d, 32'h1 << 3);
    wr(8'h28, 32'h1 << 3);
    set_pin(3, 1'b0);
    set_pin(3, 1'b1);
    rd(8'h20, d); chk("R8 gated edge", d, 0);
    cleanup();
  endtask

  task automatic t_enable();
    logic [31:0] d;
    set_sense(4, 4'h8);
    set_sense(25, 4'h8);
    set_pin(4, 1'b1); set_pin(25, 1'b1);
    rd(8'h24, d); chk("R10 status none enabled", d, 0);
    chk("R12 no irq", {30'd0, irq_hi, irq_lo}, 0);
    wr(8'h18, 32'h1 << 4);
    rd(8'h18, d); chk("R9 set", d, 32'h1 << 4);
    rd(8'h24, d); chk("R10 status", d, 32'h1 << 4);
    chk("R12 lo only", {30'd0, irq_hi, irq_lo}, 32'h1);
    wr(8'h18, 32'h0);
    rd(8'h1C, d); chk("R9 zero write", d, 32'h1 << 4);
    wr(8'h18, 32'h1 << 25);
    chk("R12 both", {30'd0, irq_hi, irq_lo}, 32'h3);
    wr(8'h1C, 32'h1 << 4);
    rd(8'h18, d); chk("R9 clear", d, 32'h1 << 25);
    chk("R12 hi only", {30'd0, irq_hi, irq_lo}, 32'h2);
    rd(8'h20, d); chk("R10 raw unaffected", d, (32'h1 << 4) | (32'h1 << 25));
    cleanup();
  endtask

  task automatic t_ack();
    logic [31:0] d;
    set_sense(6, 4'h8);
    set_sense(7, 4'h8);
    set_pin(6, 1'b1); set_pin(7, 1'b1);
    wr(8'h28, 32'h0);
    rd(8'h20, d); chk("R11 zero ack", d, 32'hC0);
    wr(8'h28, 32'h1 << 7);
    rd(8'h20, d); chk("R11 ack one", d, 32'h40);
    set_pin(6, 1'b0);
    @(negedge clk);
    pins[6] = 1'b1; we = 1'b1; addr = 8'h28; wdata = 32'h1 << 6;
    @(negedge clk);
    we = 1'b0;
    rd(8'h20, d); chk("R11 ack vs edge", d, 32'h40);
    cleanup();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) sense_sh[m] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    wr(8'h14, 32'hFFFF_FFFF);
    t_layout();
    t_rise();
    t_fall();
    t_both();
    t_level_high();
    t_level_low();
    t_invalid();
    t_accept();
    t_enable();
    t_ack();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule